// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This peripheral watches for a stalled system. Software programs an interval, turns the timer on, and must then write a fixed restart value before each interval runs out. If it fails to, the timer expires and raises either a system reset request or an interrupt, whichever the action field selects. Time is counted in half-second steps. Each step is a parameterised number of reference-clock cycles, so the block runs from a slow always-on clock and a simulation can shorten the step to a few cycles.

Stray writes are guarded in two ways. The mode and action registers accept a write only when the upper half of the write word carries a 16-bit key. The restart register reloads the count only for a 13-bit pattern: a set low bit plus a 12-bit magic value. The interval is picked by a 4-bit code through a non-linear table that reaches 16 s. Code 0 gives the shortest interval, half a second, and software uses it to force a quick reboot.

Top module: `kwdt_top`

## Requirements
- R1: A write to offset 0x10 reloads the count with the decoded interval of the current code only when data bit 0 is 1 and data bits [12:1] equal 0xA57. Any other value leaves the countdown running unchanged.
- R2: Writes to offset 0x14 (action) and offset 0x18 (mode) take effect only when data bits [31:16] equal 0x16AA. Without that key the register keeps its old value.
- R3: Reads are combinational. Offset 0x18 returns enable in bit 0, the expiry flag in bit 2 and the code in bits [7:4]. Offset 0x14 returns the action in bits [1:0]. All other bits and offsets, including the key field and offset 0x10, read as zero. After reset every register reads zero.
- R4: The interval in half-second steps is 1 for code 0, 2·c for codes 1 to 6, 16 for code 7, 20 for 8, 24 for 9, 28 for 0xA, and 32 for codes 0xB to 0xF.
- R5: On expiry, action 01 pulses the reset request and action 10 pulses the interrupt. Actions 00 and 11 drive neither output.
- R6: While the enable bit is 0 no step is counted and no expiry occurs.
- R7: When a mode write changes enable from 0 to 1, the count loads the interval of the code written in that same word. Expiry follows exactly interval × TICK_CYCLES clock edges after that write.
- R8: An expiry pulse stays high for exactly PULSE_W clock cycles, starting on the clock after the expiring edge.
- R9: Expiry sets the flag at mode bit 2. A valid restart write clears it.
- R10: After an expiry the count reloads itself and keeps running, so a neglected timer fires again one interval later.
- R11: Code 0 with enable set, followed by a valid restart, expires TICK_CYCLES edges after the restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr |
| rst_req_o | output | 1 | System reset request pulse |
| irq_o | output | 1 | Expiry interrupt pulse |

## Verification
The bench builds the block with TICK_CYCLES = 4 and PULSE_W = 3. At those values even the 16 s interval is only 128 cycles long, so every one of the sixteen codes can be timed to the exact edge. The pulse width is short enough that the reload after expiry and the next firing can both be measured. A restart that lands mid-count shows a shift of an exact, known number of edges.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

  localparam int OFS_KICK = 'h10;
  localparam int OFS_ACT  = 'h14;
  localparam int OFS_MODE = 'h18;

  localparam logic [15:0] WR_KEY     = 16'h16AA;
  localparam logic [11:0] KICK_MAGIC = 12'hA57;

  localparam int HALF_W = 6;

  typedef enum logic [1:0] {
    ACT_OFF   = 2'b00,
    ACT_RESET = 2'b01,
    ACT_IRQ   = 2'b10,
    ACT_IDLE  = 2'b11
  } act_e;

  function automatic logic [HALF_W-1:0] code_to_halves(input logic [3:0] c);
    logic [HALF_W-1:0] h;
    case (c)
      4'h0:    h = 6'd1;
      4'h1:    h = 6'd2;
      4'h2:    h = 6'd4;
      4'h3:    h = 6'd6;
      4'h4:    h = 6'd8;
      4'h5:    h = 6'd10;
      4'h6:    h = 6'd12;
      4'h7:    h = 6'd16;
      4'h8:    h = 6'd20;
      4'h9:    h = 6'd24;
      4'hA:    h = 6'd28;
      default: h = 6'd32;
    endcase
    return h;
  endfunction

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
  import kwdt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              we_i,
  input  logic              expire_i,
  output logic              en_o,
  output logic [3:0]        code_o,
  output act_e              act_o,
  output logic              load_o,
  output logic [3:0]        load_code_o,
  output logic [31:0]       rdata_o
);

  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'(OFS_KICK);
  localparam logic [ADDR_W-1:0] A_ACT  = ADDR_W'(OFS_ACT);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);

  logic       key_ok, mode_wr, act_wr, kick_ok, en_rise;
  logic       en_q, en_d;
  logic [3:0] code_q, code_d;
  act_e       act_q, act_d;
  logic       flag_q, flag_d;
  logic       unused_wdata;

  assign unused_wdata = ^wdata_i[15:13];

  always_comb begin
    key_ok  = (wdata_i[31:16] == WR_KEY);
    mode_wr = we_i && (addr_i == A_MODE) && key_ok;
    act_wr  = we_i && (addr_i == A_ACT) && key_ok;
    kick_ok = we_i && (addr_i == A_KICK) && wdata_i[0] &&
              (wdata_i[12:1] == KICK_MAGIC);
    en_rise = mode_wr && wdata_i[0] && !en_q;
  end

  always_comb begin
    en_d   = en_q;
    code_d = code_q;
    act_d  = act_q;
    flag_d = flag_q;
    if (mode_wr) begin
      en_d   = wdata_i[0];
      code_d = wdata_i[7:4];
    end
    if (act_wr) begin
      act_d = act_e'(wdata_i[1:0]);
    end
    if (expire_i) begin
      flag_d = 1'b1;
    end else if (kick_ok) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      code_q <= 4'h0;
      act_q  <= ACT_OFF;
      flag_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      code_q <= code_d;
      act_q  <= act_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = 32'h0;
    if (addr_i == A_MODE) begin
      rdata_o = {24'h0, code_q, 1'b0, flag_q, 1'b0, en_q};
    end else if (addr_i == A_ACT) begin
      rdata_o = {30'h0, act_q};
    end
  end

  assign en_o        = en_q;
  assign code_o      = code_q;
  assign act_o       = act_q;
  assign load_o      = kick_ok || en_rise;
  assign load_code_o = en_rise ? wdata_i[7:4] : code_q;

  // R2: an unkeyed mode write leaves the mode state untouched
  p_keyless_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_MODE && wdata_i[31:16] != WR_KEY)
      |=> ($stable(en_q) && $stable(code_q)));

  // R2: an unkeyed action write leaves the action untouched
  p_keyless_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_ACT && wdata_i[31:16] != WR_KEY) |=> $stable(act_q));

  // R9: expiry always leaves the flag set
  p_flag_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q);

endmodule

// File: rtl/kwdt_tick.sv
module kwdt_tick #(
  parameter int TICK_CYCLES = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic clear_i,
  output logic tick_o
);

  generate
    if (TICK_CYCLES <= 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_prescale
      localparam int PRE_W = $clog2(TICK_CYCLES);
      localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_CYCLES - 1);

      logic [PRE_W-1:0] pre_q, pre_d;
      logic             at_last;

      always_comb begin
        at_last = (pre_q == LAST);
        pre_d   = pre_q;
        if (!en_i || clear_i || at_last) begin
          pre_d = '0;
        end else begin
          pre_d = pre_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          pre_q <= '0;
        end else begin
          pre_q <= pre_d;
        end
      end

      assign tick_o = en_i && at_last;

      // R7: steps are spaced at least two clocks apart when the prescaler is active
      p_step_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count
  import kwdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       tick_i,
  input  logic       load_i,
  input  logic [3:0] load_code_i,
  input  logic [3:0] code_i,
  output logic       fire_o
);

  logic [HALF_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    fire_o = 1'b0;
    if (load_i) begin
      cnt_d = code_to_halves(load_code_i);
    end else if (en_i && tick_i) begin
      if (cnt_q == HALF_W'(1)) begin
        fire_o = 1'b1;
        cnt_d  = code_to_halves(code_i);
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  // R1: a reload leaves the count at the decoded interval of the chosen code
  p_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == code_to_halves($past(load_code_i))));

  // R7: a running timer never holds an empty count
  p_live_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |-> (cnt_q != '0));

  // R6: a stopped timer never expires
  p_stopped_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !fire_o);

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse
  import kwdt_pkg::*;
#(
  parameter int PULSE_W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire_i,
  input  act_e act_i,
  output logic rst_req_o,
  output logic irq_o
);

  localparam int LEFT_W = $clog2(PULSE_W + 1);

  logic [LEFT_W-1:0] left_q, left_d;
  act_e              kind_q, kind_d;
  logic              armed;

  always_comb begin
    armed  = fire_i && (act_i == ACT_RESET || act_i == ACT_IRQ);
    left_d = left_q;
    kind_d = kind_q;
    if (armed) begin
      left_d = LEFT_W'(PULSE_W);
      kind_d = act_i;
    end else if (left_q != '0) begin
      left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
      kind_q <= ACT_OFF;
    end else begin
      left_q <= left_d;
      kind_q <= kind_d;
    end
  end

  assign rst_req_o = (left_q != '0) && (kind_q == ACT_RESET);
  assign irq_o     = (left_q != '0) && (kind_q == ACT_IRQ);

  // R8: a reset-action expiry raises the request on the next clock
  p_reset_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && act_i == ACT_RESET) |=> rst_req_o);

  // R5: an expiry with a silent action starts no pulse
  p_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && (act_i == ACT_OFF || act_i == ACT_IDLE) && left_q == '0)
      |=> (!rst_req_o && !irq_o));

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
  import kwdt_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int TICK_CYCLES = 16000,
  parameter int PULSE_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_we,
  output logic [31:0]       bus_rdata,
  output logic              rst_req_o,
  output logic              irq_o
);

  logic       en, load, tick, fire;
  logic [3:0] code, load_code;
  act_e       act;

  kwdt_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_i      (bus_addr),
    .wdata_i     (bus_wdata),
    .we_i        (bus_we),
    .expire_i    (fire),
    .en_o        (en),
    .code_o      (code),
    .act_o       (act),
    .load_o      (load),
    .load_code_o (load_code),
    .rdata_o     (bus_rdata)
  );

  kwdt_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en),
    .clear_i (load),
    .tick_o  (tick)
  );

  kwdt_count u_count (
    .clk         (clk),
    .rst_n       (rst_n),
    .en_i        (en),
    .tick_i      (tick),
    .load_i      (load),
    .load_code_i (load_code),
    .code_i      (code),
    .fire_o      (fire)
  );

  kwdt_pulse #(.PULSE_W(PULSE_W)) u_pulse (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire_i    (fire),
    .act_i     (act),
    .rst_req_o (rst_req_o),
    .irq_o     (irq_o)
  );

endmodule

// File: tb/test_kwdt_top.sv
`timescale 1ns/1ps
module test_kwdt_top;

  localparam int TC = 4;
  localparam int PW = 3;
  localparam logic [31:0] KEYW = 32'h16AA_0000;
  localparam logic [31:0] KICK = 32'h0000_14AF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = 8'h0;
  logic [31:0] bus_wdata = 32'h0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        rst_req_o, irq_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  kwdt_top #(.ADDR_W(8), .TICK_CYCLES(TC), .PULSE_W(PW)) i_kwdt_top (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .rst_req_o(rst_req_o), .irq_o(irq_o)
  );

  function automatic int halves(input int c);
    case (c)
      0: return 1;
      7: return 16;
      8: return 20;
      9: return 24;
      10: return 28;
      default: return (c >= 1 && c <= 6) ? 2 * c : 32;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference model, updated on every rising edge
  int m_en, m_code, m_act, m_flag, m_cnt, m_pre, m_left, m_kind;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en = 0; m_code = 0; m_act = 0; m_flag = 0;
      m_cnt = 0; m_pre = 0; m_left = 0; m_kind = 0;
    end else begin
      bit kick, mw, aw, ld, tk, fr;
      int lc, n_cnt, n_pre;
      kick = bus_we && bus_addr == 8'h10 && bus_wdata[0] && bus_wdata[12:1] == 12'hA57;
      mw   = bus_we && bus_addr == 8'h18 && bus_wdata[31:16] == 16'h16AA;
      aw   = bus_we && bus_addr == 8'h14 && bus_wdata[31:16] == 16'h16AA;
      ld = 0; lc = m_code; fr = 0;
      tk = (m_en != 0) && (m_pre == TC - 1);
      if (kick) ld = 1;
      if (mw && bus_wdata[0] && m_en == 0) begin ld = 1; lc = int'(bus_wdata[7:4]); end
      n_cnt = m_cnt;
      if (ld) n_cnt = halves(lc);
      else if (tk) begin
        if (m_cnt == 1) begin fr = 1; n_cnt = halves(m_code); end
        else n_cnt = m_cnt - 1;
      end
      if (m_en == 0 || ld || tk) n_pre = 0; else n_pre = m_pre + 1;
      if (fr && (m_act == 1 || m_act == 2)) begin m_left = PW; m_kind = m_act; end
      else if (m_left > 0) m_left = m_left - 1;
      if (fr) m_flag = 1; else if (kick) m_flag = 0;
      if (mw) begin m_en = int'(bus_wdata[0]); m_code = int'(bus_wdata[7:4]); end
      if (aw) m_act = int'(bus_wdata[1:0]);
      m_cnt = n_cnt; m_pre = n_pre;
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always begin
    @(negedge clk);
    #2;
    if (rst_n) begin
      logic [31:0] exp_rd;
      bit exp_rst, exp_irq;
      exp_rst = (m_left > 0) && (m_kind == 1);
      exp_irq = (m_left > 0) && (m_kind == 2);
      if (bus_addr == 8'h18) exp_rd = 32'(m_code << 4 | m_flag << 2 | m_en);
      else if (bus_addr == 8'h14) exp_rd = 32'(m_act);
      else exp_rd = 32'h0;
      chk(rst_req_o == exp_rst, "R5/R8 model rst_req", rst_req_o, exp_rst);
      chk(irq_o == exp_irq, "R5/R8 model irq", irq_o, exp_irq);
      chk(bus_rdata == exp_rd, "R3 model rdata", bus_rdata, exp_rd);
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_rise(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(rst_req_o || irq_o) && n < 4000);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    bus_addr = a;
    #1;
    v = bus_rdata;
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int n, w, seen;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R3 reset state
    rd(8'h18, v); chk(v == 0, "R3 mode after reset", v, 0);
    rd(8'h14, v); chk(v == 0, "R3 action after reset", v, 0);
    chk(!rst_req_o && !irq_o, "R5 quiet after reset", rst_req_o, 0);

    // R2 key protection
    bus_wr(8'h14, 32'h0000_0001);
    rd(8'h14, v); chk(v == 0, "R2 unkeyed action write", v, 0);
    bus_wr(8'h14, KEYW | 32'h1);
    rd(8'h14, v); chk(v == 1, "R2/R3 keyed action write", v, 1);
    bus_wr(8'h18, 32'h16AB_0021);
    rd(8'h18, v); chk(v == 0, "R2 wrong key mode write", v, 0);
    rd(8'h10, v); chk(v == 0, "R3 restart offset reads zero", v, 0);

    // R4 / R7 full table, R8 width, R10 periodic, R9 flag
    for (int c = 0; c < 16; c++) begin
      bus_wr(8'h18, KEYW | 32'(c << 4) | 32'h1);
      wait_rise(n);
      chk(n == halves(c) * TC, "R4/R7 expiry time", n, halves(c) * TC);
      if (c == 2) begin
        w = 0;
        while (rst_req_o) begin w++; @(negedge clk); end
        chk(w == PW, "R8 pulse width", w, PW);
        wait_rise(n);
        chk(n == halves(2) * TC - PW, "R10 refire after reload", n, halves(2) * TC - PW);
      end
      bus_wr(8'h18, KEYW | 32'(c << 4));
      idle(PW + 2);
      if (c == 5) begin
        rd(8'h18, v); chk(v == 32'h54, "R9 flag set after expiry", v, 32'h54);
        bus_wr(8'h10, KICK);
        rd(8'h18, v); chk(v == 32'h50, "R9 flag cleared by restart", v, 32'h50);
      end
    end

    // R1 bad restart values are ignored, good one reloads
    bus_wr(8'h18, KEYW | 32'h31);
    idle(10);
    bus_wr(8'h10, 32'h0000_14AE);
    bus_wr(8'h10, 32'h0000_14AD);
    wait_rise(n);
    chk(n == 24 - 14, "R1 rejected restart values", n, 10);
    rd(8'h18, v); chk(v == 32'h35, "R9 flag visible while running", v, 32'h35);
    idle(PW + 1);
    bus_wr(8'h10, KICK);
    rd(8'h18, v); chk(v == 32'h31, "R9 restart clears flag", v, 32'h31);
    wait_rise(n);
    chk(n == 24, "R1 valid restart reloads", n, 24);
    bus_wr(8'h18, KEYW | 32'h30);
    idle(PW + 2);

    // R6 stop before expiry
    bus_wr(8'h18, KEYW | 32'h11);
    idle(3);
    bus_wr(8'h18, KEYW | 32'h10);
    seen = 0;
    repeat (100) begin @(negedge clk); if (rst_req_o || irq_o) seen = 1; end
    chk(seen == 0, "R6 stopped timer silent", seen, 0);

    // R5 interrupt action
    bus_wr(8'h14, KEYW | 32'h2);
    bus_wr(8'h18, KEYW | 32'h11);
    wait_rise(n);
    chk(n == 2 * TC, "R5 irq expiry time", n, 2 * TC);
    chk(irq_o && !rst_req_o, "R5 irq selects interrupt", {irq_o, rst_req_o}, 2'b10);
    bus_wr(8'h18, KEYW | 32'h10);
    idle(PW + 2);

    // R5 silent actions 00 and 11
    for (int a = 0; a < 4; a += 3) begin
      bus_wr(8'h14, KEYW | 32'(a));
      bus_wr(8'h10, KICK);
      bus_wr(8'h18, KEYW | 32'h11);
      seen = 0;
      repeat (12) begin @(negedge clk); if (rst_req_o || irq_o) seen = 1; end
      chk(seen == 0, "R5 silent action no pulse", seen, 0);
      rd(8'h18, v); chk(v[2] == 1'b1, "R5/R9 silent expiry sets flag", v[2], 1);
      bus_wr(8'h18, KEYW | 32'h10);
    end

    // R11 forced quick reboot
    bus_wr(8'h14, KEYW | 32'h1);
    bus_wr(8'h18, KEYW | 32'h01);
    bus_wr(8'h10, KICK);
    wait_rise(n);
    chk(n == TC, "R11 half-second expiry", n, TC);
    chk(rst_req_o == 1'b1, "R11 reset requested", rst_req_o, 1);
    bus_wr(8'h18, KEYW);
    idle(PW + 2);

    finish_run();
  end

endmodule